// File: doc/BRIEF.md
# Request/Complete Memory Bus Bridge

This block connects a CPU-side address register and data register to a main memory whose data path is narrower than the CPU word. The CPU loads an address (and, for a write, a data word), then raises a request with a single direction bit. The bridge splits the access into `CPU_W/MEM_W` narrow beats and runs each beat over a request/complete handshake on the memory side. When the last beat has finished, it gives the CPU a one-cycle done pulse.

Beats go to consecutive memory addresses, least significant chunk first. On a read the chunks are assembled into the data register. On a write the data register is split in the same order. A build-time option replaces the memory's complete signal with a fixed count of cycles for memories whose timing is known in advance.

Top module: `memif_bridge`

## Requirements
- R1: After reset `mem_req`, `cpu_done` and `busy` are low and `cpu_rdata` is zero.
- R2: A read (`cpu_rw`=0) from address A issues beats at A, then A+1, and so on. The chunk returned for beat k lands in bits `[k*MEM_W +: MEM_W]` of `cpu_rdata`, which holds the full word when `cpu_done` is high.
- R3: A write (`cpu_rw`=1) drives `mem_rw`=1 and sends bits `[k*MEM_W +: MEM_W]` of the loaded data word on beat k, to address A+k.
- R4: `mem_req` stays high until `mem_complete` is seen. While it is high, `mem_addr`, `mem_wdata` and `mem_rw` do not change.
- R5: After a beat completes, `mem_req` is low for at least one cycle.
- R6: `cpu_done` is a single-cycle pulse. It rises only after the complete of the last of the `CPU_W/MEM_W` beats and only while `busy` is high.
- R7: While `busy` is high, including the cycle in which `cpu_done` is high, `cpu_req`, `cpu_addr_ld` and `cpu_data_ld` are ignored.
- R8: With `FIXED_LAT`=1, `mem_complete` is ignored and each beat holds `mem_req` high for exactly `LAT_CYCLES` cycles.
- R9: Beat addresses wrap modulo 2^`ADDR_W`, so the beat after the all-ones address goes to address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_ld | input | 1 | Load the address register from `cpu_addr` (idle only) |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_data_ld | input | 1 | Load the data register from `cpu_wdata` (idle only) |
| cpu_wdata | input | CPU_W | CPU write data |
| cpu_req | input | 1 | Start an access (idle only) |
| cpu_rw | input | 1 | Direction: 1 write, 0 read |
| cpu_rdata | output | CPU_W | Data register contents |
| cpu_done | output | 1 | One-cycle pulse when the access has finished |
| busy | output | 1 | High while an access is in progress |
| mem_req | output | 1 | Memory beat request |
| mem_rw | output | 1 | Memory direction: 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory beat address |
| mem_wdata | output | MEM_W | Memory beat write data |
| mem_rdata | input | MEM_W | Memory beat read data |
| mem_complete | input | 1 | Memory beat complete |

## Verification
A new CPU request and the done pulse of the current access can fall in the same cycle, because the pulse is given while the bridge is still busy. The bench raises `cpu_req` exactly in the cycle where `cpu_done` is seen. It also raises `cpu_req` together with the address and data loads in the middle of a slow read. The bench then checks that no further beat appears on the memory side, that the done pulse is not repeated, and that a later write still uses the original address and the data that was read.

// File: rtl/memif_bridge.sv
module memif_bridge #(
  parameter int CPU_W      = 16,
  parameter int MEM_W      = 8,
  parameter int ADDR_W     = 20,
  parameter bit FIXED_LAT  = 1'b0,
  parameter int LAT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_addr_ld,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_data_ld,
  input  logic [CPU_W-1:0]  cpu_wdata,
  input  logic              cpu_req,
  input  logic              cpu_rw,
  output logic [CPU_W-1:0]  cpu_rdata,
  output logic              cpu_done,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  input  logic [MEM_W-1:0]  mem_rdata,
  input  logic              mem_complete
);
  localparam int BEATS = CPU_W / MEM_W;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CW    = $clog2(LAT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP} st_t;

  st_t               state;
  logic [ADDR_W-1:0] mar;
  logic [CPU_W-1:0]  mdr;
  logic [BW-1:0]     beat;
  logic              rw_q;
  logic [CW-1:0]     lat_cnt;
  logic              beat_ok;
  logic              last;

  assign beat_ok   = FIXED_LAT ? (lat_cnt == CW'(LAT_CYCLES - 1)) : mem_complete;
  assign last      = (beat == BW'(BEATS - 1));
  assign mem_req   = (state == S_REQ);
  assign mem_rw    = rw_q;
  assign mem_addr  = mar + ADDR_W'(beat);
  assign mem_wdata = mdr[beat*MEM_W +: MEM_W];
  assign busy      = (state != S_IDLE);
  assign cpu_done  = (state == S_GAP) && last;
  assign cpu_rdata = mdr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mar     <= '0;
      mdr     <= '0;
      beat    <= '0;
      rw_q    <= 1'b0;
      lat_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cpu_addr_ld) mar <= cpu_addr;
          if (cpu_data_ld) mdr <= cpu_wdata;
          if (cpu_req) begin
            rw_q    <= cpu_rw;
            beat    <= '0;
            lat_cnt <= '0;
            state   <= S_REQ;
          end
        end
        S_REQ: begin
          if (beat_ok) begin
            if (!rw_q) mdr[beat*MEM_W +: MEM_W] <= mem_rdata;
            state <= S_GAP;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        S_GAP: begin
          lat_cnt <= '0;
          if (last) begin
            state <= S_IDLE;
          end else begin
            beat  <= beat + 1'b1;
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module memif_bridge_chk #(
  parameter int MEM_W     = 8,
  parameter int ADDR_W    = 20,
  parameter bit FIXED_LAT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_complete,
  input logic              mem_rw,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [MEM_W-1:0]  mem_wdata,
  input logic              cpu_done,
  input logic              busy
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!FIXED_LAT && mem_req && !mem_complete) |=> mem_req);
  // R4
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_complete) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rw)));
  // R5
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!FIXED_LAT && mem_req && mem_complete) |=> !mem_req);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (busy && !mem_req));
endmodule

bind memif_bridge memif_bridge_chk #(.MEM_W(MEM_W), .ADDR_W(ADDR_W), .FIXED_LAT(FIXED_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_complete(mem_complete),
  .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cpu_done(cpu_done), .busy(busy));

// File: tb/tb_memif_bridge.sv
`timescale 1ns/1ps
module tb_memif_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        addr_ld = 0, data_ld = 0, req = 0, rw = 0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        done, busy, mem_req, mem_rw, mem_complete = 0;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  memif_bridge dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr_ld(addr_ld), .cpu_addr(addr),
    .cpu_data_ld(data_ld), .cpu_wdata(wdata), .cpu_req(req), .cpu_rw(rw),
    .cpu_rdata(rdata), .cpu_done(done), .busy(busy), .mem_req(mem_req),
    .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_complete(mem_complete));

  logic        a2_ld = 0, r2 = 0;
  logic [19:0] a2 = '0;
  logic [15:0] rd2;
  logic        done2, busy2, mreq2, mrw2;
  logic [19:0] maddr2;
  logic [7:0]  mwd2, mrd2;

  memif_bridge #(.FIXED_LAT(1'b1), .LAT_CYCLES(3)) dut2 (
    .clk(clk), .rst_n(rst_n), .cpu_addr_ld(a2_ld), .cpu_addr(a2),
    .cpu_data_ld(1'b0), .cpu_wdata(16'h0), .cpu_req(r2), .cpu_rw(1'b0),
    .cpu_rdata(rd2), .cpu_done(done2), .busy(busy2), .mem_req(mreq2),
    .mem_rw(mrw2), .mem_addr(maddr2), .mem_wdata(mwd2),
    .mem_rdata(mrd2), .mem_complete(1'b1));

  function automatic logic [7:0] f(input int i);
    return 8'(i * 37 + 5);
  endfunction

  assign mrd2 = f(int'(maddr2[7:0]));

  logic [7:0] mem [0:255];
  int dcnt = 0, mdelay = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= f(i);
      mem_complete <= 0; dcnt <= 0;
    end else if (mem_complete) begin
      mem_complete <= 0; dcnt <= 0;
    end else if (mem_req) begin
      if (dcnt == mdelay) begin
        mem_complete <= 1;
        if (mem_rw) mem[mem_addr[7:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:0]];
      end else dcnt <= dcnt + 1;
    end
  end

  int nb = 0, req2cyc = 0;
  logic [19:0] b_addr [0:63];
  logic        b_rw   [0:63];
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_complete) begin
      b_addr[nb % 64] <= mem_addr;
      b_rw[nb % 64]   <= mem_rw;
      nb <= nb + 1;
    end
    if (rst_n && mreq2) req2cyc <= req2cyc + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic cpu_access(input logic [19:0] a, input bit do_ld, input bit w,
                            input logic [15:0] d, input bit do_dld);
    @(negedge clk);
    addr_ld = do_ld; addr = a; data_ld = do_dld; wdata = d;
    @(negedge clk);
    addr_ld = 0; data_ld = 0; req = 1; rw = w;
    @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset();
    chk(!mem_req && !done && !busy && rdata == 16'h0, "R1 reset state",
        {mem_req, done, busy, rdata}, 0);
  endtask

  task automatic t_read(input logic [19:0] a, input string tag);
    int base; bit seen;
    logic [15:0] exp;
    base = nb;
    exp = {f(int'(a[7:0] + 8'd1)), f(int'(a[7:0]))};
    cpu_access(a, 1, 0, 16'h0, 0);
    wait_done(seen);
    chk(seen && rdata == exp, {tag, " read data"}, rdata, exp);
    chk(nb - base == 2, "R6 done after both beats", nb - base, 2);
    chk(b_addr[base % 64] == a && b_addr[(base + 1) % 64] == a + 20'd1,
        {tag, " beat addresses"}, b_addr[(base + 1) % 64], a + 20'd1);
    chk(!mem_req, "R5 request low at done", mem_req, 0);
    @(negedge clk);
    chk(!done, "R6 done single pulse", done, 0);
  endtask

  task automatic t_write();
    int base; bit seen;
    base = nb;
    cpu_access(20'h00010, 1, 1, 16'hBEEF, 1);
    wait_done(seen);
    chk(seen && mem[8'h10] == 8'hEF && mem[8'h11] == 8'hBE, "R3 write split",
        {mem[8'h11], mem[8'h10]}, 16'hBEEF);
    chk(b_rw[base % 64] && b_rw[(base + 1) % 64], "R3 write direction",
        {b_rw[(base + 1) % 64], b_rw[base % 64]}, 3);
    base = nb;
    cpu_access(20'h00010, 1, 0, 16'h0, 0);
    wait_done(seen);
    chk(rdata == 16'hBEEF, "R2 read back written word", rdata, 16'hBEEF);
  endtask

  task automatic t_busy_ignore();
    int base, settle; bit seen;
    logic [15:0] exp;
    exp = {f(8'h21), f(8'h20)};
    mdelay = 3;
    base = nb;
    cpu_access(20'h00020, 1, 0, 16'h0, 0);
    addr_ld = 1; addr = 20'h00040; data_ld = 1; wdata = 16'h1234; req = 1; rw = 1;
    @(negedge clk);
    addr_ld = 0; data_ld = 0; req = 0; rw = 0;
    wait_done(seen);
    req = 1; rw = 1;
    @(negedge clk);
    req = 0; rw = 0;
    chk(rdata == exp, "R7 read unaffected by busy loads", rdata, exp);
    repeat (8) @(negedge clk);
    settle = nb;
    chk(settle - base == 2 && !mem_req && !busy, "R7 request during busy/done ignored",
        settle - base, 2);
    base = nb;
    cpu_access(20'h0, 0, 1, 16'h0, 0);
    wait_done(seen);
    chk(b_addr[base % 64] == 20'h00020, "R7 address load ignored while busy",
        b_addr[base % 64], 20'h00020);
    chk(mem[8'h20] == f(8'h20) && mem[8'h21] == f(8'h21), "R7 data load ignored while busy",
        {mem[8'h21], mem[8'h20]}, exp);
    mdelay = 0;
  endtask

  task automatic t_fixed();
    int c0; bit seen;
    logic [15:0] exp;
    exp = {f(8'h34), f(8'h33)};
    c0 = req2cyc;
    @(negedge clk); a2_ld = 1; a2 = 20'h00033;
    @(negedge clk); a2_ld = 0; r2 = 1;
    @(negedge clk); r2 = 0;
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      if (done2) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen && req2cyc - c0 == 6, "R8 fixed latency cycles", req2cyc - c0, 6);
    chk(rd2 == exp, "R8 fixed latency read data", rd2, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read(20'h00005, "R2");
    mdelay = 2;
    t_read(20'h0A0C7, "R2 slow");
    mdelay = 0;
    t_read(20'hFFFFF, "R9 wrap");
    t_write();
    t_busy_ignore();
    t_fixed();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule